// File: doc/BRIEF.md
# Bus Controller Power-Mode Sequencer

This block decides the operating mode of a byte-level serial bus protocol controller. Software writes a two-bit control field that holds an enable bit and a disable bit. The sequencer checks each write. It rejects the one forbidden combination and holds back an enable that arrives in the same write that drops disable. From the stored field it decodes one of three power modes: Enabled, Suspended or Disabled.

For each mode the block drives a gate for the transmit/receive logic and a gate for the bus symbol decoder. It also drives two sets of synchronous clear strobes. The shallow set holds the status register, the error register and the sleep flag at reset. The deep set holds the interrupt mask and the two end-of-block flags at reset, and it takes effect only after disable has been held for a minimum number of cycles. A bus-synchronised flag drops while the block is Disabled. Once disable is released, the flag rises again only after a new bus-idle indication. In Suspended mode the flag is kept, so moving from Suspended to Enabled needs no idle wait.

The controlled registers are modelled as small stubs inside the block, so the effect of each clear can be seen at the ports.

Top module: `bus_pwr_seq`

## Requirements
- R1: The mode output is decoded from the stored control bits. It is 2'b00 (Disabled) when enable=0 and disable=1, 2'b01 (Suspended) when both bits are 0, and 2'b10 (Enabled) when enable=1 and disable=0. The stored bits are never both 1.
- R2: A write with enable=1 and disable=1 leaves the stored bits unchanged. In the cycle after that write, the illegal-write output is high for one cycle.
- R3: If a write clears disable while disable currently reads 1, the enable bit of that write is ignored and the block goes to Suspended. A later write with enable=1 and disable=0 goes to Enabled.
- R4: The transceiver gate is high only in Enabled mode with the synchronised flag high. Status, error and sleep events are captured only while this gate is high.
- R5: The shallow clear is high whenever the mode is not Enabled. The status register, the error register and the sleep flag read 0 one cycle after any cycle in which the shallow clear was high.
- R6: The deep clear is high only from the 6th consecutive cycle with stored disable=1 (parameter HOLD_CYC). It then clears the interrupt mask and both end-of-block flags. A disable held for fewer cycles leaves all three unchanged.
- R7: The synchronised flag, which is also the decoder gate, goes low one cycle after any cycle with stored disable=1. With disable=0 it rises one cycle after bus_idle is sampled high.
- R8: On a change from Suspended to Enabled, the synchronised flag stays high and the transceiver gate opens in the next cycle, without a bus-idle indication.
- R9: After reset the mode is Disabled, the synchronised flag and the illegal-write flag are low, the hold count is zero, and all stub registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control field write strobe |
| cfg_en | input | 1 | Enable bit of the write |
| cfg_dis | input | 1 | Disable bit of the write |
| bus_idle | input | 1 | Bus idle detected |
| ev_status | input | REG_W | Status bits to set |
| ev_error | input | REG_W | Error bits to set |
| imask_wr | input | 1 | Interrupt mask write strobe |
| imask_wdata | input | REG_W | Interrupt mask write data |
| ev_sleep | input | 1 | Sleep flag set event |
| ev_teob | input | 1 | Transmit end-of-block set event |
| ev_reob | input | 1 | Receive end-of-block set event |
| mode_o | output | 2 | Decoded mode |
| ctl_en_o | output | 1 | Stored enable bit |
| ctl_dis_o | output | 1 | Stored disable bit |
| wr_illegal_o | output | 1 | Forbidden write pulse |
| xcvr_en_o | output | 1 | Transmit/receive gate |
| dec_en_o | output | 1 | Symbol decoder gate |
| bus_synced_o | output | 1 | Synchronised to bus |
| clr_shallow_o | output | 1 | Clear for status, error and sleep |
| clr_deep_o | output | 1 | Clear for mask and end-of-block flags |
| status_o | output | REG_W | Status stub |
| error_o | output | REG_W | Error stub |
| imask_o | output | REG_W | Interrupt mask stub |
| sleep_o | output | 1 | Sleep flag |
| teob_o | output | 1 | Transmit end-of-block flag |
| reob_o | output | 1 | Receive end-of-block flag |

## Verification
The bench targets disable pulses of exactly five and exactly six cycles. A design with an off-by-one hold count would either wipe the interrupt mask too early or never wipe it at all. It also writes enable together with a falling disable; a design that honoured that enable would jump to Enabled while still unsynchronised. Forbidden writes go in with both prior states. A design that stored them would show both bits set, and one that did not flag them would leave the illegal pulse low. The bench also leaves bus_idle low after disable is released, and then switches Suspended to Enabled with no idle. This exposes a flag that rises too early or one that wrongly waits for idle.

// File: rtl/bus_pwr_seq_pkg.sv
package bus_pwr_seq_pkg;

  typedef enum logic [1:0] {
    PM_DISABLED  = 2'b00,
    PM_SUSPENDED = 2'b01,
    PM_ENABLED   = 2'b10
  } pm_mode_e;

  typedef struct packed {
    logic en;
    logic dis;
  } pm_ctl_t;

  localparam pm_ctl_t PM_CTL_RESET = '{en: 1'b0, dis: 1'b1};

  // Mode from stored bits; enable has priority since both set never occurs.
  function automatic pm_mode_e decode_mode(pm_ctl_t c);
    if (c.en)       return PM_ENABLED;
    else if (c.dis) return PM_DISABLED;
    else            return PM_SUSPENDED;
  endfunction

  function automatic logic is_forbidden(logic wen, logic wdis);
    return wen & wdis;
  endfunction

  // Enable is masked when the write is the one that drops disable.
  function automatic pm_ctl_t apply_write(pm_ctl_t cur, logic wen, logic wdis);
    pm_ctl_t r;
    r.dis = wdis;
    r.en  = wen & ~(cur.dis & ~wdis);
    return r;
  endfunction

  // Count holds the number of earlier consecutive cycles; the current one adds one.
  function automatic logic hold_met(int cnt, int need);
    return (cnt + 1) >= need;
  endfunction

endpackage

// File: rtl/pm_ctl_reg.sv
module pm_ctl_reg
  import bus_pwr_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  logic    wen,
  input  logic    wdis,
  output pm_ctl_t ctl_q,
  output logic    illegal_q,
  output logic    en_blocked
);

  logic forbidden;
  logic accept;

  assign forbidden  = wr & is_forbidden(wen, wdis);
  assign accept     = wr & ~is_forbidden(wen, wdis);
  assign en_blocked = accept & ctl_q.dis & ~wdis & wen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= PM_CTL_RESET;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= forbidden;
      if (accept) ctl_q <= apply_write(ctl_q, wen, wdis);
    end
  end

  // R1: stored bits never both set
  a_r1_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_q.en && ctl_q.dis));

  // R2: forbidden write keeps state and pulses the flag
  a_r2_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wen && wdis) |=> ($stable({ctl_q.en, ctl_q.dis}) && illegal_q));

  // R2: the flag only follows a forbidden write
  a_r2_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !(wen && wdis)) |=> !illegal_q);

  // R3: enable in the releasing write lands in Suspended
  a_r3_en_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    en_blocked |=> (!ctl_q.en && !ctl_q.dis));

endmodule

// File: rtl/pm_hold_timer.sv
module pm_hold_timer
  import bus_pwr_seq_pkg::*;
#(
  parameter int HOLD_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  output logic deep_clr
);

  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] SAT = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!dis)       cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign deep_clr = dis & hold_met(int'(cnt_q), HOLD_CYC);

  // R6: a released disable cannot leave the deep clear on
  a_r6_quiet_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    !dis |=> (!deep_clr || dis));

  // R6: deep clear is never the first disable cycle
  a_r6_not_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis) |-> !deep_clr);

endmodule

// File: rtl/pm_bus_sync.sv
module pm_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  input  logic bus_idle,
  output logic synced_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        synced_q <= 1'b0;
    else if (dis)      synced_q <= 1'b0;
    else if (bus_idle) synced_q <= 1'b1;
  end

  // R7: disabled drops synchronisation
  a_r7_low_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> !synced_q);

  // R7: rising needs an idle seen while not disabled
  a_r7_rise_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(synced_q) |-> $past(bus_idle && !dis));

endmodule

// File: rtl/pm_hold_reg.sv
module pm_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic         set_en,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (clr)    q <= '0;
    else if (ld)     q <= ld_data;
    else if (set_en) q <= q | set_bits;
  end

endmodule

// File: rtl/bus_pwr_seq.sv
module bus_pwr_seq
  import bus_pwr_seq_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int HOLD_CYC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             cfg_en,
  input  logic             cfg_dis,
  input  logic             bus_idle,
  input  logic [REG_W-1:0] ev_status,
  input  logic [REG_W-1:0] ev_error,
  input  logic             imask_wr,
  input  logic [REG_W-1:0] imask_wdata,
  input  logic             ev_sleep,
  input  logic             ev_teob,
  input  logic             ev_reob,
  output logic [1:0]       mode_o,
  output logic             ctl_en_o,
  output logic             ctl_dis_o,
  output logic             wr_illegal_o,
  output logic             xcvr_en_o,
  output logic             dec_en_o,
  output logic             bus_synced_o,
  output logic             clr_shallow_o,
  output logic             clr_deep_o,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] error_o,
  output logic [REG_W-1:0] imask_o,
  output logic             sleep_o,
  output logic             teob_o,
  output logic             reob_o
);

  localparam int EOB_W = 2;

  pm_ctl_t  ctl;
  pm_mode_e mode;
  logic     illegal;
  logic     en_blocked;
  logic     synced;
  logic     deep_clr;
  logic     shallow_clr;
  logic     xcvr_en;
  logic [EOB_W-1:0] eob_q;

  pm_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wen(cfg_en), .wdis(cfg_dis),
    .ctl_q(ctl), .illegal_q(illegal), .en_blocked(en_blocked)
  );

  pm_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .dis(ctl.dis), .deep_clr(deep_clr)
  );

  pm_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .dis(ctl.dis), .bus_idle(bus_idle), .synced_q(synced)
  );

  assign mode        = decode_mode(ctl);
  assign shallow_clr = (mode != PM_ENABLED);
  assign xcvr_en     = (mode == PM_ENABLED) & synced;

  pm_hold_reg #(.W(REG_W)) u_status (
    .clk(clk), .rst_n(rst_n), .clr(shallow_clr), .ld(1'b0), .ld_data('0),
    .set_en(xcvr_en), .set_bits(ev_status), .q(status_o)
  );

  pm_hold_reg #(.W(REG_W)) u_error (
    .clk(clk), .rst_n(rst_n), .clr(shallow_clr), .ld(1'b0), .ld_data('0),
    .set_en(xcvr_en), .set_bits(ev_error), .q(error_o)
  );

  pm_hold_reg #(.W(REG_W)) u_imask (
    .clk(clk), .rst_n(rst_n), .clr(deep_clr), .ld(imask_wr), .ld_data(imask_wdata),
    .set_en(1'b0), .set_bits('0), .q(imask_o)
  );

  pm_hold_reg #(.W(1)) u_sleep (
    .clk(clk), .rst_n(rst_n), .clr(shallow_clr), .ld(1'b0), .ld_data(1'b0),
    .set_en(xcvr_en), .set_bits(ev_sleep), .q(sleep_o)
  );

  pm_hold_reg #(.W(EOB_W)) u_eob (
    .clk(clk), .rst_n(rst_n), .clr(deep_clr), .ld(1'b0), .ld_data('0),
    .set_en(xcvr_en), .set_bits({ev_reob, ev_teob}), .q(eob_q)
  );

  assign teob_o        = eob_q[0];
  assign reob_o        = eob_q[1];
  assign mode_o        = mode;
  assign ctl_en_o      = ctl.en;
  assign ctl_dis_o     = ctl.dis;
  assign wr_illegal_o  = illegal;
  assign xcvr_en_o     = xcvr_en;
  assign dec_en_o      = synced;
  assign bus_synced_o  = synced;
  assign clr_shallow_o = shallow_clr;
  assign clr_deep_o    = deep_clr;

  // R4: transceiver gate needs synchronisation
  a_r4_xcvr_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    xcvr_en |-> (synced && ctl.en));

  // R5: shallow clear empties its registers by the next cycle
  a_r5_shallow_empties: assert property (@(posedge clk) disable iff (!rst_n)
    shallow_clr |=> (status_o == '0 && error_o == '0 && !sleep_o));

  // R6: deep clear empties mask and end-of-block flags
  a_r6_deep_empties: assert property (@(posedge clk) disable iff (!rst_n)
    deep_clr |=> (imask_o == '0 && eob_q == '0));

  // R8: Suspended to Enabled keeps synchronisation
  a_r8_keep_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && !ctl.dis) |=> synced);

endmodule

// File: tb/bus_pwr_seq_tb.sv
module bus_pwr_seq_tb_top;

  localparam int W    = 8;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_en = 0, cfg_dis = 0, bus_idle = 0;
  logic [W-1:0] ev_status = '0, ev_error = '0, imask_wdata = '0;
  logic imask_wr = 0, ev_sleep = 0, ev_teob = 0, ev_reob = 0;

  logic [1:0] mode_o;
  logic ctl_en_o, ctl_dis_o, wr_illegal_o, xcvr_en_o, dec_en_o, bus_synced_o;
  logic clr_shallow_o, clr_deep_o, sleep_o, teob_o, reob_o;
  logic [W-1:0] status_o, error_o, imask_o;

  bus_pwr_seq #(.REG_W(W), .HOLD_CYC(HOLD)) dut_i (.*);

  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Behavioural reference state
  int m_en = 0, m_dis = 1, m_run = 0, m_sync = 0, m_ill = 0;
  int m_status = 0, m_error = 0, m_imask = 0, m_sleep = 0, m_teob = 0, m_reob = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_dis = 1; m_run = 0; m_sync = 0; m_ill = 0;
      m_status = 0; m_error = 0; m_imask = 0; m_sleep = 0; m_teob = 0; m_reob = 0;
    end else begin
      int o_en, o_dis, o_sync, o_run, running;
      o_en = m_en; o_dis = m_dis; o_sync = m_sync; o_run = m_run;
      running = (o_en == 1 && o_sync == 1);
      m_ill = (cfg_wr && cfg_en && cfg_dis) ? 1 : 0;
      if (cfg_wr && !(cfg_en && cfg_dis)) begin
        m_dis = cfg_dis;
        m_en  = (o_dis == 1 && !cfg_dis) ? 0 : int'(cfg_en);
      end
      if (o_dis == 1) m_sync = 0;
      else if (bus_idle) m_sync = 1;
      m_run = (o_dis == 1) ? o_run + 1 : 0;
      if (o_en == 0) begin
        m_status = 0; m_error = 0; m_sleep = 0;
      end else if (running) begin
        m_status = m_status | int'(ev_status);
        m_error  = m_error  | int'(ev_error);
        if (ev_sleep) m_sleep = 1;
      end
      if (o_dis == 1 && o_run >= HOLD - 1) begin
        m_imask = 0; m_teob = 0; m_reob = 0;
      end else begin
        if (imask_wr) m_imask = int'(imask_wdata);
        if (running && ev_teob) m_teob = 1;
        if (running && ev_reob) m_reob = 1;
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int e_mode;
    e_mode = (m_en == 1) ? 2 : ((m_dis == 1) ? 0 : 1);
    chk("R1", "mode", int'(mode_o), e_mode);
    chk("R3", "ctl_en", int'(ctl_en_o), m_en);
    chk("R3", "ctl_dis", int'(ctl_dis_o), m_dis);
    chk("R2", "illegal", int'(wr_illegal_o), m_ill);
    chk("R4", "xcvr_en", int'(xcvr_en_o), (m_en == 1 && m_sync == 1) ? 1 : 0);
    chk("R7", "synced", int'(bus_synced_o), m_sync);
    chk("R7", "dec_en", int'(dec_en_o), m_sync);
    chk("R5", "clr_shallow", int'(clr_shallow_o), (m_en == 0) ? 1 : 0);
    chk("R6", "clr_deep", int'(clr_deep_o), (m_dis == 1 && m_run >= HOLD - 1) ? 1 : 0);
    chk("R5", "status", int'(status_o), m_status);
    chk("R5", "error", int'(error_o), m_error);
    chk("R5", "sleep", int'(sleep_o), m_sleep);
    chk("R6", "imask", int'(imask_o), m_imask);
    chk("R6", "teob", int'(teob_o), m_teob);
    chk("R6", "reob", int'(reob_o), m_reob);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      cfg_wr = 0; imask_wr = 0;
    end
  endtask

  task automatic wr_ctl(logic e, logic d);
    cfg_wr = 1; cfg_en = e; cfg_dis = d;
    step(1);
  endtask

  function automatic logic [31:0] xs(logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  initial begin
    logic [31:0] seed;
    // R9: reset state
    step(3);
    chk("R9", "reset mode", int'(mode_o), 0);
    chk("R9", "reset synced", int'(bus_synced_o), 0);
    rst_n = 1;
    // R6: deep clear only from the 6th disable cycle
    step(HOLD + 2);
    // leave Disabled with no idle: R7 flag must stay low
    wr_ctl(1'b0, 1'b0);
    step(4);
    chk("R7", "no idle no sync", int'(bus_synced_o), 0);
    bus_idle = 1; step(1); bus_idle = 0; step(1);
    chk("R7", "sync after idle", int'(bus_synced_o), 1);
    wr_ctl(1'b1, 1'b0);
    ev_status = 8'h5A; ev_error = 8'h81; ev_sleep = 1; ev_teob = 1; ev_reob = 1;
    imask_wr = 1; imask_wdata = 8'hC3;
    step(2);
    ev_status = '0; ev_error = '0; ev_sleep = 0; ev_teob = 0; ev_reob = 0;
    // R2: forbidden write while Enabled
    wr_ctl(1'b1, 1'b1);
    chk("R2", "illegal pulse", int'(wr_illegal_o), 1);
    step(1);
    // R8: Suspended then Enabled without idle
    wr_ctl(1'b0, 1'b0);
    step(2);
    wr_ctl(1'b1, 1'b0);
    chk("R8", "xcvr immediate", int'(xcvr_en_o), 1);
    // R6: five-cycle disable keeps mask; R3 releasing write with enable
    wr_ctl(1'b0, 1'b1);
    step(HOLD - 2);
    wr_ctl(1'b1, 1'b0);
    chk("R3", "releasing enable ignored", int'(mode_o), 1);
    chk("R6", "short pulse keeps mask", int'(imask_o), 'hC3);
    // R2: forbidden write while Suspended
    wr_ctl(1'b1, 1'b1);
    // R6: exactly six-cycle disable clears mask
    wr_ctl(1'b0, 1'b1);
    step(HOLD - 1);
    wr_ctl(1'b0, 1'b0);
    chk("R6", "six cycles clear mask", int'(imask_o), 0);
    // pseudorandom traffic
    seed = 32'h1234_5678;
    for (int k = 0; k < 4000; k++) begin
      seed = xs(seed);
      cfg_wr = (seed[2:0] == 3'd0);
      cfg_en = seed[3]; cfg_dis = seed[4] & seed[5];
      bus_idle = (seed[7:6] == 2'b00);
      ev_status = seed[15:8]; ev_error = seed[23:16] & seed[31:24];
      imask_wr = (seed[27:25] == 3'd1); imask_wdata = seed[31:24];
      ev_sleep = seed[28]; ev_teob = seed[29]; ev_reob = seed[30];
      @(negedge clk);
      compare_all();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule